// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a register-mapped port for general-purpose pins. It sits on a simple word-wide memory-mapped bus. For every pin it keeps a direction bit and an output value bit, and it drives both straight onto the `pin_oe` and `pin_out` vectors. Software changes directions through two addresses. Writing ones to the first address turns pins into outputs. Writing ones to the second address turns pins back into inputs. Zero bits in either write leave the matching pins as they were.

Output values are written as two half-words, one for the low half of the pins and one for the high half. In each data word, the upper half acts as a per-bit enable for the lower half. This lets a single pin change without a read-modify-write sequence. The stored value is kept while a pin is still an input, so software can load a level first and then turn the driver on. The input pins pass through a synchronizer chain, and the synchronized levels can be read back over the bus.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` all 0), all stored output bits are 0, and `bus_rdata` and `bus_rvalid` are 0.
- R2: A write to offset 0x00 sets the direction bit of every pin whose written bit is 1. Pins whose written bit is 0 keep their direction.
- R3: A write to offset 0x04 clears the direction bit of every pin whose written bit is 1. Pins whose written bit is 0 keep their direction.
- R4: A write to offset 0x08 updates output bit k (k = 0..15) to written bit k only when written bit k+16 is 1. All other output bits hold their value.
- R5: A write to offset 0x0C uses the same enable rule for pins 16..31: written bit k maps to pin k+16, with enable in bit k+16. Pins 0..15 are left unchanged.
- R6: Stored output values stay unchanged across direction writes. They persist while a pin is an input, so a preloaded value appears on `pin_out` and is driven once the pin is switched to output.
- R7: A read of offset 0x10 returns the pin levels after a two-flop synchronizer. A change on `pin_in` is not returned by reads captured at the first or second clock edge after the change. It is returned from the third edge on.
- R8: A read of offset 0x00 or 0x04 returns the current direction vector (1 = output).
- R9: A read of offset 0x08 or 0x0C returns the 16 stored output bits of that half in bits 15..0, with bits 31..16 reading as 0.
- R10: Read data is registered. A read request at one clock edge gives `bus_rvalid` = 1 and valid `bus_rdata` after that edge, for one cycle.
- R11: Offsets other than the five listed read as 0, and writes to them change neither direction nor output data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address, word aligned |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | DATA_W (32) | Asynchronous pin levels |
| pin_out | output | DATA_W (32) | Stored output values |
| pin_oe | output | DATA_W (32) | Output enables (direction bits) |

## Verification
Direction and output writes take effect at the clock edge that accepts them. The bench therefore checks `pin_oe` and `pin_out` at the falling edge that follows. A read returns its data one edge after the request, and the bench samples `bus_rdata` at the falling edge after that capturing edge. Input levels need two more edges to pass the synchronizer. The bench changes `pin_in` and then issues reads captured at the first, second and third edges, expecting the old level, the old level and the new level.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // word index = byte address [4:2]
  localparam logic [2:0] IDX_DIR_SET = 3'd0;
  localparam logic [2:0] IDX_DIR_CLR = 3'd1;
  localparam logic [2:0] IDX_OUT_LO  = 3'd2;
  localparam logic [2:0] IDX_OUT_HI  = 3'd3;
  localparam logic [2:0] IDX_PIN_RD  = 3'd4;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] dir
);
  logic [W-1:0] set_m, clr_m;
  assign set_m = set_en ? bits : '0;
  assign clr_m = clr_en ? bits : '0;

  always_ff @(posedge clk) begin
    if (rst) dir <= '0;
    else     dir <= (dir | set_m) & ~clr_m;
  end

  // R2
  dir_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((dir & $past(bits)) == $past(bits)));
  // R3
  dir_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((dir & $past(bits)) == '0));
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en || clr_en) |=> (((dir ^ $past(dir)) & ~$past(bits)) == '0));
endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0]   val
);
  logic [HW-1:0] en, nv;
  assign nv = wdata[HW-1:0];
  assign en = wr_en ? wdata[2*HW-1:HW] : '0;

  always_ff @(posedge clk) begin
    if (rst) val <= '0;
    else     val <= (val & ~en) | (nv & en);
  end

  // R4
  half_update_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (((val ^ $past(wdata[HW-1:0])) & $past(wdata[2*HW-1:HW])) == '0));
  // R4
  half_mask_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (((val ^ $past(val)) & ~$past(wdata[2*HW-1:HW])) == '0));
  // R6
  half_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(val));
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NHALF  = 2;

  logic [2:0]        idx;
  logic              hit_hi;
  logic              wr, rd;
  logic [DATA_W-1:0] pins_s;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] rmux;

  assign idx    = bus_addr[4:2];
  assign hit_hi = (ADDR_W > 5) ? (bus_addr >> 5) != '0 : 1'b0;
  assign wr     = bus_sel && bus_we && !hit_hi && (bus_addr[1:0] == 2'b00);
  assign rd     = bus_sel && !bus_we;

  gpio_pin_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_s)
  );

  gpio_dir_ctrl #(.W(DATA_W)) u_dir (
    .clk(clk), .rst(rst),
    .set_en(wr && idx == IDX_DIR_SET),
    .clr_en(wr && idx == IDX_DIR_CLR),
    .bits(bus_wdata),
    .dir(pin_oe)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    gpio_out_half #(.HW(HALF_W)) u_half (
      .clk(clk), .rst(rst),
      .wr_en(wr && idx == (IDX_OUT_LO + 3'(h))),
      .wdata(bus_wdata),
      .val(out_q[h*HALF_W +: HALF_W])
    );
  end

  assign pin_out = out_q;

  always_comb begin
    rmux = '0;
    if (!hit_hi && bus_addr[1:0] == 2'b00) begin
      case (idx)
        IDX_DIR_SET, IDX_DIR_CLR: rmux = pin_oe;
        IDX_OUT_LO: rmux = {{HALF_W{1'b0}}, out_q[HALF_W-1:0]};
        IDX_OUT_HI: rmux = {{HALF_W{1'b0}}, out_q[DATA_W-1:HALF_W]};
        IDX_PIN_RD: rmux = pins_s;
        default:    rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rmux;
    end
  end

  // R10
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid);
  // R10
  rvalid_only_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !bus_rvalid);
  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && idx > IDX_OUT_HI) |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/masked_gpio_port_tb.sv
module masked_gpio_port_tb;
  logic        clk = 0;
  logic        rst;
  logic        bus_sel, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        bus_rvalid;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  masked_gpio_port u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    chk("R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    rst = 1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
  endtask

  task automatic t_dir;
    wr(5'h00, 32'hF0F0_00FF);
    chk("R2 set", pin_oe, 32'hF0F0_00FF);
    wr(5'h00, 32'h0000_0100);
    chk("R2 zeros keep", pin_oe, 32'hF0F0_01FF);
    wr(5'h04, 32'h8000_0001);
    chk("R3 clear", pin_oe, 32'h70F0_01FE);
    wr(5'h04, 32'h0);
    chk("R3 zeros keep", pin_oe, 32'h70F0_01FE);
    rd(5'h00, rv); chk("R8 read 0x00", rv, 32'h70F0_01FE);
    rd(5'h04, rv); chk("R8 read 0x04", rv, 32'h70F0_01FE);
    wr(5'h04, 32'hFFFF_FFFF);
    chk("R3 clear all", pin_oe, 32'h0);
  endtask

  task automatic t_out;
    wr(5'h08, 32'hFFFF_A5A5);
    chk("R4 full low", pin_out, 32'h0000_A5A5);
    wr(5'h08, 32'h0003_0000);
    chk("R4 masked", pin_out, 32'h0000_A5A4);
    wr(5'h08, 32'h0000_FFFF);
    chk("R4 no enable", pin_out, 32'h0000_A5A4);
    wr(5'h0C, 32'h8001_FFFF);
    chk("R5 high", pin_out, 32'h8001_A5A4);
    rd(5'h08, rv); chk("R9 low read", rv, 32'h0000_A5A4);
    rd(5'h0C, rv); chk("R9 high read", rv, 32'h0000_8001);
  endtask

  task automatic t_preload;
    wr(5'h0C, 32'h0040_0040);
    chk("R6 preload as input", pin_out, 32'h8041_A5A4);
    chk("R6 still input", pin_oe, 32'h0);
    wr(5'h00, 32'h0040_0000);
    chk("R6 value kept", pin_out, 32'h8041_A5A4);
    chk("R6 now output", pin_oe, 32'h0040_0000);
    wr(5'h04, 32'h0040_0000);
    chk("R6 kept after clear", pin_out, 32'h8041_A5A4);
  endtask

  task automatic t_sync;
    pin_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rd(5'h10, rv); chk("R7 settled", rv, 32'h1234_5678);
    pin_in = 32'hCAFE_0001;
    rd(5'h10, rv); chk("R7 edge1 old", rv, 32'h1234_5678);
    rd(5'h10, rv); chk("R7 edge2 old", rv, 32'h1234_5678);
    rd(5'h10, rv); chk("R7 edge3 new", rv, 32'hCAFE_0001);
  endtask

  task automatic t_unmapped;
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    chk("R11 dir untouched", pin_oe, 32'h0);
    chk("R11 out untouched", pin_out, 32'h8041_A5A4);
    rd(5'h18, rv); chk("R11 read zero", rv, 32'h0);
  endtask

  initial begin
    t_reset;
    t_dir;
    t_out;
    t_preload;
    t_sync;
    t_unmapped;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule